// File: doc/BRIEF.md
# Predicate-Aware Multi-Definition Dependence Table

This block tracks, for every logical register, a small set of in-flight definitions that may still reach a later reader. Each definition is held in a slot together with the tag of the instruction that wrote it. If that instruction was guarded by a predicate, the slot also holds the path-entry number of the guarding predicate. When a consumer is presented with two source registers and its own guard, the block returns one dependence mask per source, with one bit per slot. It leaves out any definition whose guarding path is disjoint from the consumer's guarding path. The block does not decide disjointness itself. For each slot of both selected registers it shows the stored path, along with the consumer's path, on a query interface, and an external responder returns one disjoint bit per slot.

Definitions leave the table in two ways. A tag-matched clear removes a slot, either when the defining instruction retires or when its guard has resolved false. An unguarded definition of the register also removes every slot of that register. When a guarded definition finds every slot of its register occupied, it replaces the oldest slot and marks the register as overflowed. From then on, a lookup of that register raises a wait flag so that the consumer holds back conservatively.

Top module: `pdt_table`

## Requirements
- R1: Each logical register owns `WAYS` slots (4 by default, 16 as the alternative). A slot holds a valid bit, a guarded bit, a path entry and a tag. An unguarded definition is stored with the guarded bit clear and path entry 0.
- R2: A guarded definition is written into the lowest-numbered free slot of its register. Bit i of a dependence mask corresponds to slot i.
- R3: An unguarded definition empties every other slot of its register. It then takes slot 0 and clears that register's overflow mark.
- R4: A guarded definition to a register with no free slot overwrites the slot that holds the oldest surviving definition and sets the register's overflow mark. The mark stays set until an unguarded definition of that register.
- R5: A clear with a given tag invalidates the slot holding that tag, whichever register it belongs to. Such a clear stands for either retirement or a guard that resolved false. Later lookups no longer see that slot.
- R6: The results of a lookup appear on the cycle after `lk_valid`, with `res_vld` high. Bit i of a mask is set when slot i is valid, unless both the slot and the consumer are guarded and the responder reports the pair disjoint.
- R7: `qry_path0`/`qry_path1` show the stored path entry of each slot of the register selected by `lk_src0`/`lk_src1`, and `qry_cons` shows `lk_path`. A disjoint bit is ignored whenever either side is unguarded.
- R8: A lookup of register 0 returns an all-zero mask and no wait, even after a definition of register 0.
- R9: A lookup made in the same cycle as a definition of the same register does not see that definition.
- R10: After reset every slot is empty, every overflow mark is clear, and all result outputs are zero.
- R11: `wait0`/`wait1` report the overflow mark of the looked-up register, one cycle after the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| def_valid | input | 1 | A definition is written this cycle |
| def_reg | input | 3 | Logical register being defined |
| def_tag | input | 6 | Tag of the defining instruction |
| def_grd | input | 1 | Definition is guarded by a predicate |
| def_path | input | 4 | Path entry of the guarding predicate |
| clr_valid | input | 1 | Remove the slot whose tag matches |
| clr_tag | input | 6 | Tag to remove |
| lk_valid | input | 1 | A consumer lookup is presented |
| lk_src0 | input | 3 | First source register |
| lk_src1 | input | 3 | Second source register |
| lk_grd | input | 1 | Consumer is guarded |
| lk_path | input | 4 | Consumer's guarding path entry |
| qry_path0 | output | 4x4 | Slot path entries of the first source register |
| qry_path1 | output | 4x4 | Slot path entries of the second source register |
| qry_cons | output | 4 | Consumer path entry offered to the responder |
| disj0 | input | 4 | Responder: slot i of source 0 is disjoint from the consumer |
| disj1 | input | 4 | Responder: slot i of source 1 is disjoint from the consumer |
| res_vld | output | 1 | Lookup result valid |
| dep0 | output | 4 | Dependence mask for source 0 |
| dep1 | output | 4 | Dependence mask for source 1 |
| wait0 | output | 1 | Source 0 register has overflowed |
| wait1 | output | 1 | Source 1 register has overflowed |

## Verification
The assertions rely on three conditions holding at the inputs. Tags in flight are unique. A clear never names the tag being defined in the same cycle. The responder's disjoint bits are settled before the clock edge. The stimulus meets these conditions by handing out a fresh tag for every definition, by clearing only tags that were defined in earlier steps, and by computing the disjoint bits combinationally from a fixed path relation (1 against 2, 3 against 4, and 3 or 4 against 2). Register 0 and the same-cycle case are driven on purpose, so the suppression rules are exercised rather than avoided.

// File: rtl/pdt_pkg.sv
// Shared widths and the slot record used by every table row.
// Assumes tags are unique among in-flight instructions.
package pdt_pkg;
    localparam int TAG_W  = 6;
    localparam int PATH_W = 4;

    typedef struct packed {
        logic              vld;
        logic              grd;
        logic [PATH_W-1:0] path;
        logic [TAG_W-1:0]  tag;
    } slot_t;
endpackage

// File: rtl/pdt_row.sv
// One logical register's set of definition slots.
// It applies a tag clear first and then a definition, and keeps valid ages
// compact (0..count-1), so that when the row is full the oldest slot is
// the one whose age is WAYS-1.
// Assumes at most one slot per row matches a clear tag.
module pdt_row #(
    parameter int WAYS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          def_hit,
    input  logic                          def_grd,
    input  logic [pdt_pkg::PATH_W-1:0]    def_path,
    input  logic [pdt_pkg::TAG_W-1:0]     def_tag,
    input  logic                          clr_valid,
    input  logic [pdt_pkg::TAG_W-1:0]     clr_tag,
    output pdt_pkg::slot_t [WAYS-1:0]     slots,
    output logic                          ovf
);
    localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1;

    pdt_pkg::slot_t [WAYS-1:0] slots_q, slots_d;
    logic [WAYS-1:0][AW-1:0]   age_q, age_d;
    logic                      ovf_q, ovf_d;
    logic [WAYS-1:0]           vld_vec;

    // Valid bits gathered for the checks
    always_comb begin
        for (int i = 0; i < WAYS; i++) vld_vec[i] = slots_q[i].vld;
    end

    // Next-state: tag clear, age compaction, then definition insert
    always_comb begin
        logic          gone;
        logic [AW-1:0] gone_age;
        logic          free_fnd;
        logic [AW-1:0] free_idx;
        logic [AW-1:0] old_idx;
        logic [AW-1:0] tgt;
        slots_d  = slots_q;
        age_d    = age_q;
        ovf_d    = ovf_q;
        gone     = 1'b0;
        gone_age = '0;
        free_fnd = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        tgt      = '0;
        if (clr_valid) begin
            for (int i = 0; i < WAYS; i++) begin
                if (!gone && slots_d[i].vld && slots_d[i].tag == clr_tag) begin
                    gone           = 1'b1;
                    gone_age       = age_d[i];
                    slots_d[i].vld = 1'b0;
                end
            end
        end
        if (gone) begin
            for (int i = 0; i < WAYS; i++) begin
                if (slots_d[i].vld && age_d[i] > gone_age) age_d[i] = age_d[i] - 1'b1;
            end
        end
        if (def_hit) begin
            if (!def_grd) begin
                for (int i = 0; i < WAYS; i++) slots_d[i].vld = 1'b0;
                slots_d[0] = '{vld: 1'b1, grd: 1'b0, path: '0, tag: def_tag};
                age_d      = '0;
                ovf_d      = 1'b0;
            end else begin
                for (int i = WAYS - 1; i >= 0; i--) begin
                    if (!slots_d[i].vld) begin
                        free_fnd = 1'b1;
                        free_idx = AW'(i);
                    end
                    if (slots_d[i].vld && age_d[i] == AW'(WAYS - 1)) old_idx = AW'(i);
                end
                tgt = free_fnd ? free_idx : old_idx;
                if (!free_fnd) ovf_d = 1'b1;
                for (int i = 0; i < WAYS; i++) begin
                    if (slots_d[i].vld) age_d[i] = age_d[i] + 1'b1;
                end
                slots_d[tgt] = '{vld: 1'b1, grd: 1'b1, path: def_path, tag: def_tag};
                age_d[tgt]   = '0;
            end
        end
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            age_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            slots_q <= slots_d;
            age_q   <= age_d;
            ovf_q   <= ovf_d;
        end
    end

    assign slots = slots_q;
    assign ovf   = ovf_q;

    // R3: an unguarded definition leaves one unguarded slot 0 and no overflow mark
    p_kill_leaves_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        def_hit && !def_grd |=> $countones(vld_vec) == 1 && slots_q[0].vld
                                && !slots_q[0].grd && !ovf_q);

    // R4: the overflow mark only rises after a guarded insert into a full row
    p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(def_hit && def_grd && (&vld_vec)));

    // R4: a guarded insert keeps the overflow mark set
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !(def_hit && !def_grd) |=> ovf_q);
endmodule

// File: rtl/pdt_pick.sv
// Forms one source operand's dependence mask from the selected row.
// A slot counts unless both sides are guarded and the responder says the
// paths are disjoint. Assumes disj is settled before the clock edge.
module pdt_pick #(
    parameter int WAYS = 4
) (
    input  pdt_pkg::slot_t [WAYS-1:0]               slots,
    input  logic                                    active,
    input  logic                                    cons_grd,
    input  logic [WAYS-1:0]                         disj,
    output logic [WAYS-1:0]                         dep,
    output logic [WAYS-1:0]                         vmask,
    output logic [WAYS-1:0][pdt_pkg::PATH_W-1:0]    qpath
);
    // Per-slot dependence decision and query path
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            vmask[i] = slots[i].vld;
            qpath[i] = slots[i].path;
            dep[i]   = active && slots[i].vld
                       && !(slots[i].grd && cons_grd && disj[i]);
        end
    end
endmodule

// File: rtl/pdt_table.sv
// Top: one row per logical register, two lookup pickers, registered results.
// A lookup reads the table state from before this cycle's updates, so a
// definition written in the same cycle is not seen.
// Assumes NREGS is a power of two.
module pdt_table #(
    parameter int WAYS  = 4,
    parameter int NREGS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   def_valid,
    input  logic [$clog2(NREGS)-1:0]               def_reg,
    input  logic [pdt_pkg::TAG_W-1:0]              def_tag,
    input  logic                                   def_grd,
    input  logic [pdt_pkg::PATH_W-1:0]             def_path,
    input  logic                                   clr_valid,
    input  logic [pdt_pkg::TAG_W-1:0]              clr_tag,
    input  logic                                   lk_valid,
    input  logic [$clog2(NREGS)-1:0]               lk_src0,
    input  logic [$clog2(NREGS)-1:0]               lk_src1,
    input  logic                                   lk_grd,
    input  logic [pdt_pkg::PATH_W-1:0]             lk_path,
    output logic [WAYS-1:0][pdt_pkg::PATH_W-1:0]   qry_path0,
    output logic [WAYS-1:0][pdt_pkg::PATH_W-1:0]   qry_path1,
    output logic [pdt_pkg::PATH_W-1:0]             qry_cons,
    input  logic [WAYS-1:0]                        disj0,
    input  logic [WAYS-1:0]                        disj1,
    output logic                                   res_vld,
    output logic [WAYS-1:0]                        dep0,
    output logic [WAYS-1:0]                        dep1,
    output logic                                   wait0,
    output logic                                   wait1
);
    localparam int RW = $clog2(NREGS);

    pdt_pkg::slot_t [WAYS-1:0] row_slots [NREGS];
    logic [NREGS-1:0]          row_ovf;
    logic [WAYS-1:0]           dep_c0, dep_c1, vm0, vm1;
    logic                      act0, act1;

    for (genvar r = 0; r < NREGS; r++) begin : g_row
        pdt_row #(.WAYS(WAYS)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .def_hit  (def_valid && def_reg == RW'(r)),
            .def_grd  (def_grd),
            .def_path (def_path),
            .def_tag  (def_tag),
            .clr_valid(clr_valid),
            .clr_tag  (clr_tag),
            .slots    (row_slots[r]),
            .ovf      (row_ovf[r])
        );
    end

    assign act0     = lk_valid && lk_src0 != '0;
    assign act1     = lk_valid && lk_src1 != '0;
    assign qry_cons = lk_path;

    pdt_pick #(.WAYS(WAYS)) u_pick0 (
        .slots(row_slots[lk_src0]), .active(act0), .cons_grd(lk_grd),
        .disj(disj0), .dep(dep_c0), .vmask(vm0), .qpath(qry_path0)
    );
    pdt_pick #(.WAYS(WAYS)) u_pick1 (
        .slots(row_slots[lk_src1]), .active(act1), .cons_grd(lk_grd),
        .disj(disj1), .dep(dep_c1), .vmask(vm1), .qpath(qry_path1)
    );

    // Result registers, one cycle after the lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            dep0    <= '0;
            dep1    <= '0;
            wait0   <= 1'b0;
            wait1   <= 1'b0;
        end else begin
            res_vld <= lk_valid;
            dep0    <= dep_c0;
            dep1    <= dep_c1;
            wait0   <= act0 && row_ovf[lk_src0];
            wait1   <= act1 && row_ovf[lk_src1];
        end
    end

    // R8: register 0 never yields a dependence or a wait
    p_reg0_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && $past(lk_src0) == '0 |-> dep0 == '0 && !wait0);

    // R6: every reported dependence points at a slot that was valid
    p_dep_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (dep0 & ~$past(vm0)) == '0 && (dep1 & ~$past(vm1)) == '0);

    // R6: no result without a lookup in the cycle before
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> dep0 == '0 && dep1 == '0 && !wait0 && !wait1);
endmodule

// File: tb/pdt_table_test.sv
module pdt_table_test;
    localparam int WAYS = 4;

    typedef struct packed {
        bit       d;
        bit       c;
        bit       l;
        bit [2:0] rg;
        bit [5:0] tg;
        bit       g;
        bit [3:0] pth;
        bit [2:0] s1;
        bit [3:0] e0;
        bit [3:0] e1;
        bit       w0;
        bit       w1;
    } vec_t;

    localparam int NV = 23;
    // d c l reg tag g path s1 exp0 exp1 w0 w1
    localparam vec_t VEC [NV] = '{
        '{1,0,0,3'd5,6'd1, 0,4'd0,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 1,4'd2,3'd0,4'b0001,4'b0000,0,0}, // R1 R8
        '{1,0,0,3'd5,6'd2, 1,4'd1,3'd0,4'b0000,4'b0000,0,0},
        '{1,0,0,3'd5,6'd3, 1,4'd2,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 1,4'd2,3'd6,4'b0101,4'b0000,0,0}, // R2 R6
        '{0,0,1,3'd5,6'd0, 0,4'd0,3'd6,4'b0111,4'b0000,0,0}, // R7
        '{0,1,0,3'd0,6'd2, 0,4'd0,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 1,4'd1,3'd0,4'b0001,4'b0000,0,0}, // R5
        '{1,0,0,3'd5,6'd4, 1,4'd3,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 1,4'd1,3'd0,4'b0011,4'b0000,0,0}, // R2
        '{1,0,0,3'd5,6'd5, 1,4'd4,3'd0,4'b0000,4'b0000,0,0},
        '{1,0,0,3'd5,6'd6, 1,4'd1,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 1,4'd2,3'd0,4'b0100,4'b0000,1,0}, // R4 R11
        '{1,0,0,3'd5,6'd7, 1,4'd2,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 0,4'd0,3'd5,4'b1111,4'b1111,1,1}, // R4 R11
        '{1,0,1,3'd3,6'd8, 0,4'd0,3'd0,4'b0000,4'b0000,0,0}, // R9
        '{0,0,1,3'd3,6'd0, 0,4'd0,3'd0,4'b0001,4'b0000,0,0}, // R9
        '{1,0,0,3'd5,6'd9, 0,4'd0,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd5,6'd0, 1,4'd1,3'd3,4'b0001,4'b0001,0,0}, // R3
        '{0,1,0,3'd0,6'd8, 0,4'd0,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd3,6'd0, 1,4'd1,3'd5,4'b0000,4'b0001,0,0}, // R5
        '{1,0,0,3'd0,6'd10,0,4'd0,3'd0,4'b0000,4'b0000,0,0},
        '{0,0,1,3'd0,6'd0, 0,4'd0,3'd0,4'b0000,4'b0000,0,0}  // R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic def_valid = 1'b0, def_grd = 1'b0, clr_valid = 1'b0;
    logic lk_valid = 1'b0, lk_grd = 1'b0;
    logic [2:0] def_reg = '0, lk_src0 = '0, lk_src1 = '0;
    logic [5:0] def_tag = '0, clr_tag = '0;
    logic [3:0] def_path = '0, lk_path = '0;
    logic [WAYS-1:0][3:0] qry_path0, qry_path1;
    logic [3:0] qry_cons;
    logic [WAYS-1:0] disj0, disj1, dep0, dep1;
    logic res_vld, wait0, wait1;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    pdt_table uut (
        .clk(clk), .rst_n(rst_n), .def_valid(def_valid), .def_reg(def_reg),
        .def_tag(def_tag), .def_grd(def_grd), .def_path(def_path),
        .clr_valid(clr_valid), .clr_tag(clr_tag), .lk_valid(lk_valid),
        .lk_src0(lk_src0), .lk_src1(lk_src1), .lk_grd(lk_grd), .lk_path(lk_path),
        .qry_path0(qry_path0), .qry_path1(qry_path1), .qry_cons(qry_cons),
        .disj0(disj0), .disj1(disj1), .res_vld(res_vld), .dep0(dep0),
        .dep1(dep1), .wait0(wait0), .wait1(wait1)
    );

    function automatic bit is_disj(input logic [3:0] a, input logic [3:0] b);
        return (a == 1 && b == 2) || (a == 2 && b == 1) ||
               (a == 3 && b == 4) || (a == 4 && b == 3) ||
               (a == 3 && b == 2) || (a == 2 && b == 3) ||
               (a == 4 && b == 2) || (a == 2 && b == 4);
    endfunction

    // Query responder driven from the fixed path relation
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            disj0[i] = is_disj(qry_path0[i], qry_cons);
            disj1[i] = is_disj(qry_path1[i], qry_cons);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        def_valid = 0; clr_valid = 0; lk_valid = 0;
    endtask

    task automatic do_def(input logic [2:0] r, input logic [5:0] t, input logic g, input logic [3:0] p);
        def_valid = 1; def_reg = r; def_tag = t; def_grd = g; def_path = p;
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic do_look(input logic [2:0] a, input logic [2:0] b, input logic g, input logic [3:0] p);
        lk_valid = 1; lk_src0 = a; lk_src1 = b; lk_grd = g; lk_path = p;
        @(posedge clk); @(negedge clk); idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset outputs", {res_vld, dep0, dep1, wait0, wait1}, '0);
        rst_n = 1;
        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            def_valid = VEC[k].d; def_reg = VEC[k].rg; def_tag = VEC[k].tg;
            def_grd = VEC[k].g; def_path = VEC[k].pth;
            clr_valid = VEC[k].c; clr_tag = VEC[k].tg;
            lk_valid = VEC[k].l; lk_src0 = VEC[k].rg; lk_src1 = VEC[k].s1;
            lk_grd = VEC[k].g; lk_path = VEC[k].pth;
            @(posedge clk); @(negedge clk);
            idle();
            if (VEC[k].l)
                check($sformatf("R6 vector %0d dep/wait", k),
                      {res_vld, dep0, dep1, wait0, wait1},
                      {1'b1, VEC[k].e0, VEC[k].e1, VEC[k].w0, VEC[k].w1});
        end
        // Directed: reset empties the table
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        check("R10 outputs in reset", {res_vld, dep0, dep1, wait0, wait1}, '0);
        rst_n = 1;
        do_look(3'd5, 3'd3, 1'b0, 4'd0);
        check("R10 table empty after reset", {res_vld, dep0, dep1, wait0, wait1}, {1'b1, 10'd0});
        // Directed: query interface shows slot paths
        do_def(3'd2, 6'd1, 1'b1, 4'd3);
        do_def(3'd2, 6'd2, 1'b1, 4'd4);
        lk_src0 = 3'd2; lk_path = 4'd7;
        #1;
        check("R7 query slot0 path", 32'(qry_path0[0]), 32'd3);
        check("R7 query slot1 path", 32'(qry_path0[1]), 32'd4);
        check("R7 query consumer path", 32'(qry_cons), 32'd7);
        do_look(3'd2, 3'd0, 1'b1, 4'd3);
        check("R6 same path kept, disjoint dropped", 32'(dep0), 32'b0001);
        do_look(3'd2, 3'd0, 1'b1, 4'd2);
        check("R6 both disjoint", 32'(dep0), 32'b0000);
        do_look(3'd2, 3'd0, 1'b0, 4'd2);
        check("R7 unguarded consumer ignores disjoint", 32'(dep0), 32'b0011);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule